// File: doc/BRIEF.md
# Interrupt status and enable controller

This block collects event and error conditions from a host controller's queue logic into a single 32-bit interrupt status word and drives one interrupt line from it. A condition vector enters on `cond_in`, one bit per status position. A status-enable mask chooses which conditions may reach the status word. A separate signal-enable mask chooses which status bits may drive `irq_o`. A force register lets software set status bits through the normal path, so the interrupt route can be tested without provoking real faults.

Status bits are of two kinds. Level bits mirror their live input, so they show threshold and ready conditions. Sticky bits cover events, latency warnings and errors, and programming errors. A sticky bit latches on its event and holds until software writes a one to it. Software reaches the block through a simple single-cycle register port. Writes take effect at the clock edge, and reads return data combinationally.

Top module: `intr_status_ctrl`

## Requirements
- R1: After reset the status word, status-enable, signal-enable and `irq_o` are all zero.
- R2: Level bits 0 to 4 (TX threshold, RX threshold, IBI status threshold, command queue ready, response ready) read as `cond_in & status_enable` in the same cycle. Writes to status (0x20) and force (0x2C) do not change them.
- R3: Sticky bits 5, 7, 9 and 12 to 25 set at the clock edge where their `cond_in` bit is 1 and status-enable allows it. They stay set after the input drops.
- R4: Writing to the status register at offset 0x20 clears each sticky bit written with a 1. Bits written with 0 are unchanged.
- R5: If a condition event and a write-one-to-clear hit the same sticky bit in the same cycle, the bit stays set.
- R6: A status-enable bit of 0 keeps that condition out of status: the level bit reads 0 and the sticky bit does not latch.
- R7: Writing 1s to the force register at offset 0x2C sets the matching sticky bits that status-enable allows. The force register reads back as zero.
- R8: `irq_o` is the OR of (status AND signal-enable), registered one clock after status changes.
- R9: With signal-enable all zero, `irq_o` stays 0 while status bits still record.
- R10: Status-enable (0x24) and signal-enable (0x28) read back masked to the implemented bits 0x03FFF2BF. Unimplemented status bits always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| cond_in | input | 32 | Condition inputs, one per status bit |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench first holds a level pattern on several ready and threshold inputs. It then writes all ones to clear and to force, which tells live-following bits apart from latched ones. Short pulses on a mixed pair of sticky bits are followed by partial clears, which separates per-bit clearing from whole-word clearing. A pulse held through a clear of the same bit shows whether the event wins the collision. Partial status-enable masks and targeted signal-enable masks, checked cycle by cycle on `irq_o`, show the two masking stages acting independently, along with the single-cycle output latency.

// File: rtl/intr_status_ctrl.sv
module intr_status_ctrl #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'h20,
  parameter logic [ADDR_W-1:0] STEN_ADDR  = 8'h24,
  parameter logic [ADDR_W-1:0] SIGEN_ADDR = 8'h28,
  parameter logic [ADDR_W-1:0] FORCE_ADDR = 8'h2C,
  parameter logic [DATA_W-1:0] LEVEL_MASK  = 32'h0000_001F,
  parameter logic [DATA_W-1:0] STICKY_MASK = 32'h03FF_F2A0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] cond_in,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] IMPL_MASK = LEVEL_MASK | STICKY_MASK;

  logic [DATA_W-1:0] sten_q, sigen_q, sticky_q;
  logic [DATA_W-1:0] status_w, set_w, clr_w, force_w;
  logic wr_stat, wr_sten, wr_sigen, wr_force;

  assign wr_stat  = reg_wr && (reg_addr == STAT_ADDR);
  assign wr_sten  = reg_wr && (reg_addr == STEN_ADDR);
  assign wr_sigen = reg_wr && (reg_addr == SIGEN_ADDR);
  assign wr_force = reg_wr && (reg_addr == FORCE_ADDR);

  assign force_w  = wr_force ? reg_wdata : '0;
  assign clr_w    = wr_stat ? reg_wdata : '0;
  assign set_w    = (cond_in | force_w) & sten_q & STICKY_MASK;
  assign status_w = sticky_q | (cond_in & sten_q & LEVEL_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sten_q   <= '0;
      sigen_q  <= '0;
      sticky_q <= '0;
      irq_o    <= 1'b0;
    end else begin
      if (wr_sten)  sten_q  <= reg_wdata & IMPL_MASK;
      if (wr_sigen) sigen_q <= reg_wdata & IMPL_MASK;
      sticky_q <= (sticky_q & ~clr_w) | set_w;
      irq_o    <= |(status_w & sigen_q);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == STAT_ADDR)  reg_rdata = status_w;
    if (reg_addr == STEN_ADDR)  reg_rdata = sten_q;
    if (reg_addr == SIGEN_ADDR) reg_rdata = sigen_q;
  end
endmodule

// File: rtl/intr_status_ctrl_chk.sv
module intr_status_ctrl_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h20,
  parameter logic [DATA_W-1:0] STICKY_MASK = 32'h03FF_F2A0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] cond_in,
  input logic [DATA_W-1:0] status,
  input logic [DATA_W-1:0] sten,
  input logic [DATA_W-1:0] sigen,
  input logic              irq_o
);
  logic [DATA_W-1:0] clr_vec;
  assign clr_vec = (reg_wr && reg_addr == STAT_ADDR) ? reg_wdata : '0;

  p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(status) & STICKY_MASK & ~$past(clr_vec)) & ~status) == '0));

  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == STAT_ADDR) |=>
      ((status & STICKY_MASK & $past(reg_wdata) & ~$past(cond_in)) == '0));

  p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(cond_in & sten) & STICKY_MASK) & ~status) == '0));

  p_latch_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status) & STICKY_MASK & ~$past(sten)) == '0));

  p_irq_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|$past(status & sigen)));

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sigen) == '0) |-> !irq_o);
endmodule

bind intr_status_ctrl intr_status_ctrl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .STICKY_MASK(STICKY_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cond_in(cond_in), .status(status_w),
  .sten(sten_q), .sigen(sigen_q), .irq_o(irq_o)
);

// File: tb/intr_status_ctrl_tb_top.sv
module intr_status_ctrl_tb_top;
  localparam logic [7:0] A_STAT = 8'h20, A_STEN = 8'h24, A_SIGEN = 8'h28, A_FORCE = 8'h2C;
  localparam logic [31:0] IMPL = 32'h03FF_F2BF;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, irq_o;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, cond_in = '0;

  typedef struct { bit is_irq; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  item_t it;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  intr_status_ctrl dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cond_in(cond_in), .irq_o(irq_o));

  always @(negedge clk) begin
    if (q.size() > 0) begin
      it = q.pop_front();
      n_chk++;
      if (it.is_irq) begin
        if (irq_o !== it.exp[0]) begin
          n_fail++;
          $display("FAIL %s: irq_o=%0b expected %0b", it.tag, irq_o, it.exp[0]);
        end
      end else if (reg_rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s: rdata=%h expected %h", it.tag, reg_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t x;
    reg_addr = a;
    x.is_irq = 1'b0; x.exp = e; x.tag = tag;
    q.push_back(x);
    @(posedge clk); #1;
  endtask

  task automatic chk_irq(input bit e, input string tag);
    item_t x;
    x.is_irq = 1'b1; x.exp = {31'b0, e}; x.tag = tag;
    q.push_back(x);
    @(posedge clk); #1;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk_rd(A_STAT, 32'h0, "R1 status");
        chk_rd(A_STEN, 32'h0, "R1 sten");
        chk_rd(A_SIGEN, 32'h0, "R1 sigen");
        chk_irq(1'b0, "R1 irq");

        wr(A_STEN, 32'hFFFF_FFFF);
        chk_rd(A_STEN, IMPL, "R10 sten readback");

        cond_in = 32'h0000_001B;
        chk_rd(A_STAT, 32'h0000_001B, "R2 live level");
        wr(A_STAT, 32'hFFFF_FFFF);
        chk_rd(A_STAT, 32'h0000_001B, "R2 level ignores clear");
        wr(A_FORCE, 32'h0000_001F);
        chk_rd(A_STAT, 32'h0000_001B, "R2 level ignores force");
        chk_rd(A_FORCE, 32'h0, "R7 force reads zero");
        cond_in = 32'h0;
        chk_rd(A_STAT, 32'h0, "R2 level drops");

        cond_in = 32'h0000_2020;
        @(posedge clk); #1 cond_in = 32'h0;
        chk_rd(A_STAT, 32'h0000_2020, "R3 sticky latch");
        wr(A_STAT, 32'h0000_0020);
        chk_rd(A_STAT, 32'h0000_2000, "R4 partial clear");
        wr(A_STAT, 32'h0000_2000);
        chk_rd(A_STAT, 32'h0, "R4 second clear");

        cond_in = 32'h0010_0000;
        @(posedge clk); #1;
        wr(A_STAT, 32'h0010_0000);
        cond_in = 32'h0;
        chk_rd(A_STAT, 32'h0010_0000, "R5 event beats clear");
        wr(A_STAT, 32'h0010_0000);
        chk_rd(A_STAT, 32'h0, "R4 clear after collision");

        wr(A_STEN, IMPL & ~32'h0000_0202);
        cond_in = 32'h0000_0202;
        chk_rd(A_STAT, 32'h0, "R6 masked level");
        cond_in = 32'h0;
        chk_rd(A_STAT, 32'h0, "R6 masked sticky not latched");

        wr(A_FORCE, 32'h00C0_0200);
        chk_rd(A_STAT, 32'h00C0_0000, "R7 force gated by sten");
        wr(A_STEN, 32'hFFFF_FFFF);
        wr(A_STAT, 32'hFFFF_FFFF);
        chk_rd(A_STAT, 32'h0, "R4 clear all");

        wr(A_SIGEN, 32'h0040_0000);
        chk_irq(1'b0, "R8 irq idle");
        wr(A_FORCE, 32'h0040_0000);
        chk_irq(1'b0, "R8 irq one cycle latency");
        chk_irq(1'b1, "R8 irq asserted");
        wr(A_STAT, 32'h0040_0000);
        chk_irq(1'b1, "R8 irq holds one cycle");
        chk_irq(1'b0, "R8 irq drops");

        wr(A_SIGEN, 32'h0000_0010);
        cond_in = 32'h0000_0010;
        idle(1);
        chk_irq(1'b1, "R8 irq from level bit");
        cond_in = 32'h0;
        idle(1);
        chk_irq(1'b0, "R8 irq follows level drop");

        wr(A_SIGEN, 32'h0);
        wr(A_FORCE, 32'h03FF_F000);
        idle(2);
        chk_irq(1'b0, "R9 no irq with sigen zero");
        chk_rd(A_STAT, 32'h03FF_F000, "R9 status still records");
        wr(A_SIGEN, 32'hFFFF_FFFF);
        chk_rd(A_SIGEN, IMPL, "R10 sigen readback");
        chk_irq(1'b1, "R8 irq after sigen set");
        wr(A_FORCE, 32'hFFFF_FFFF);
        chk_rd(A_STAT, 32'h03FF_F2A0, "R10 reserved bits zero");
        idle(2);
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_chk++; n_fail++;
          $display("FAIL watchdog: done=0 expected 1");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule